// File: doc/BRIEF.md
# LCD Palette Load Sequencer

This block sits at the input of an LCD controller, where a memory reader delivers 32-bit words over a valid/ready handshake. When the controller is enabled, a load-mode setting decides what the stream holds. The stream may open with a colour palette that is followed by frame data. It may hold a palette alone. It may hold frame data alone. Palette words are unpacked into 16-bit halfwords and written into a 256-entry table of 12-bit RGB444 colours. The format code in the first halfword sets how many entries the palette carries.

Frame words are handed on unchanged to the downstream frame path, with handshaking passed straight through. A status flag reports that a palette has been taken in. When only a palette was loaded, software can clear that flag by writing a one. In the other modes the flag stays set until the controller is disabled. A separate read port turns an 8-bit pixel index into its 12-bit colour, with one cycle of latency.

Top module: `lcd_pal_loader`

## Requirements
- R1: While `en` is low, `s_ready`, `fr_valid` and `pal_loaded` are all low. Dropping `en` clears `pal_loaded` in every mode.
- R2: `load_mode` is sampled in the first cycle that `en` is high. 0 selects palette then frame, 1 selects palette only, 2 selects frame only, and 3 acts like 2.
- R3: Each palette word holds two halfwords. The lower halfword goes to the even entry 2k and the upper halfword to entry 2k+1. Of each halfword, bits [11:0] are stored (red [11:8], green [7:4], blue [3:0]) and bits [15:12] are ignored, except in the very first halfword.
- R4: Bits [15:12] of the first halfword are a format code. Entry 0 still receives bits [11:0] of that halfword.
- R5: Code 3 gives 256 entries. Codes 0, 1 and 2 give 128 entries. Code 4 and any code above 4 give 16 entries. A palette load takes entries/2 + 1 words, and the last word is discarded without writing any entry.
- R6: Throughout the palette phase `s_ready` is high and `fr_valid` is low.
- R7: In mode 1, `pal_loaded` goes high in the cycle after the last palette word is accepted. After that, `s_ready` stays low until `en` falls.
- R8: A one on `clr_loaded` clears `pal_loaded` only when the current load uses mode 1. In modes 0 and 2 it has no effect.
- R9: In the frame phase, `fr_valid` equals `s_valid`, `fr_data` equals `s_data`, and `s_ready` equals `fr_ready`.
- R10: Words taken in mode 2 never change a palette entry.
- R11: `rd_rgb` shows the entry selected by `rd_idx` one clock after `rd_idx` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable; a rising level starts a load sequence |
| load_mode | input | 2 | Sequencing select, sampled at start |
| clr_loaded | input | 1 | Write-one-to-clear for the palette-loaded flag |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word ready |
| s_data | input | 32 | Input word |
| fr_valid | output | 1 | Frame word valid to the downstream path |
| fr_ready | input | 1 | Downstream ready |
| fr_data | output | 32 | Frame word to the downstream path |
| pal_loaded | output | 1 | Palette-loaded status |
| rd_idx | input | 8 | Pixel index for lookup |
| rd_rgb | output | 12 | RGB444 colour of the indexed entry |

## Verification
A wrong word counter or a wrong decode of the format code first shows up in the handshake. `pal_loaded` rises one word early or late, and in mode 0 `fr_valid` opens up at the wrong word. Either error can be seen in the cycle that follows the last palette word. A bad halfword-to-entry mapping produces no handshake symptom. It appears only when the lookup port reads back a colour, so the bench compares entries at both ends of each palette size and at the first entry past it.

// File: rtl/lcd_pal_loader.sv
module lcd_pal_loader #(
  parameter int IDX_W  = 8,
  parameter int CLR_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        load_mode,
  input  logic              clr_loaded,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              fr_valid,
  input  logic              fr_ready,
  output logic [WORD_W-1:0] fr_data,
  output logic              pal_loaded,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CLR_W-1:0]  rd_rgb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int HALF_W  = WORD_W / 2;
  localparam int CNT_W   = IDX_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_PAL, S_FRAME, S_HOLD} st_t;

  st_t             st;
  logic [1:0]      mode_q;
  logic [CNT_W-1:0] wcnt, last_q, last_first, last_idx;
  logic [CLR_W-1:0] pal [ENTRIES];
  logic [3:0]      code;
  logic            first, pal_xfer, pal_end;
  logic [IDX_W-1:0] idx_lo, idx_hi;

  assign code  = s_data[HALF_W-1 -: 4];
  assign first = (st == S_PAL) && (wcnt == '0);

  always_comb begin
    if (code == 4'd3)      last_first = CNT_W'(ENTRIES / 2);
    else if (code < 4'd3)  last_first = CNT_W'(ENTRIES / 4);
    else                   last_first = CNT_W'(8);
  end

  assign last_idx = first ? last_first : last_q;
  assign s_ready  = (st == S_PAL) || ((st == S_FRAME) && fr_ready);
  assign fr_valid = (st == S_FRAME) && s_valid;
  assign fr_data  = s_data;
  assign pal_xfer = (st == S_PAL) && s_valid;
  assign pal_end  = pal_xfer && (wcnt == last_idx);
  assign idx_lo   = {wcnt[IDX_W-2:0], 1'b0};
  assign idx_hi   = {wcnt[IDX_W-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= 2'd0;
      wcnt   <= '0;
      last_q <= '0;
    end else if (!en) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          mode_q <= load_mode;
          wcnt   <= '0;
          st     <= (load_mode[1] == 1'b0) ? S_PAL : S_FRAME;
        end
        S_PAL: if (pal_xfer) begin
          if (first) last_q <= last_first;
          wcnt <= wcnt + 1'b1;
          if (pal_end) st <= (mode_q == 2'd1) ? S_HOLD : S_FRAME;
        end
        default: st <= st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               pal_loaded <= 1'b0;
    else if (!en)                             pal_loaded <= 1'b0;
    else if (pal_end)                         pal_loaded <= 1'b1;
    else if (clr_loaded && mode_q == 2'd1 && st != S_IDLE) pal_loaded <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (en && pal_xfer && !pal_end) begin
      pal[idx_lo] <= s_data[CLR_W-1:0];
      pal[idx_hi] <= s_data[HALF_W+CLR_W-1:HALF_W];
    end
    rd_rgb <= pal[rd_idx];
  end

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pal_loaded && !s_ready && !fr_valid));

  p_frame_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_IDLE && load_mode[1]) |=> (st == S_FRAME || !en));

  p_pal_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_loaded) |-> ($past(st) == S_PAL));

  p_pal_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAL) |-> (s_ready && !fr_valid));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && en) |=> (!s_ready && (st == S_HOLD || !en)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_loaded && en && mode_q != 2'd1) |=> (pal_loaded || !en));

  p_frame_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FRAME) |-> (fr_valid == s_valid && s_ready == fr_ready));
endmodule

// File: tb/lcd_pal_loader_test.sv
module lcd_pal_loader_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, en = 0, clr_loaded = 0, s_valid = 0, fr_ready = 0;
  logic [1:0] load_mode = 0;
  logic [31:0] s_data = 0;
  logic [7:0] rd_idx = 0;
  logic s_ready, fr_valid, pal_loaded;
  logic [31:0] fr_data;
  logic [11:0] rd_rgb;

  int n_chk = 0, n_fail = 0;
  int exp_pal [256];
  bit fwd_seen;

  always #(CLK_P/2) clk = ~clk;

  lcd_pal_loader uut (.clk(clk), .rst_n(rst_n), .en(en), .load_mode(load_mode),
    .clr_loaded(clr_loaded), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data),
    .pal_loaded(pal_loaded), .rd_idx(rd_idx), .rd_rgb(rd_rgb));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [11:0] colour(input int i, input int seed);
    return 12'((i * 53 + seed * 17 + 3) & 12'hfff);
  endfunction

  task automatic push(input logic [31:0] w, output int waits);
    bit ok;
    waits = 0;
    s_valid = 1; s_data = w;
    do begin
      #1 ok = s_ready;
      if (ok && fr_valid) fwd_seen = 1;
      if (!ok) waits++;
      @(negedge clk);
    end while (!ok && waits < 50);
    s_valid = 0;
  endtask

  task automatic read_chk(input int idx, input string req);
    rd_idx = 8'(idx);
    @(negedge clk);
    chk(rd_rgb == 12'(exp_pal[idx]), req, rd_rgb, exp_pal[idx]);
  endtask

  task automatic load_pal(input logic [1:0] mode, input logic [3:0] code, input int seed);
    int nent, nw, waits, stalls;
    nent = (code == 3) ? 256 : (code < 3) ? 128 : 16;
    nw = nent / 2 + 1;
    stalls = 0; fwd_seen = 0;
    load_mode = mode; en = 1;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word;
      if (w == nw - 1) word = 32'h7123_7456;
      else begin
        word[15:0]  = {(w == 0) ? code : 4'h9, colour(2*w, seed)};
        word[31:16] = {4'hB, colour(2*w+1, seed)};
        exp_pal[2*w]   = colour(2*w, seed);
        exp_pal[2*w+1] = colour(2*w+1, seed);
      end
      push(word, waits);
      if (w > 0) stalls += waits;
      if (w < nw - 1) chk(pal_loaded == 0, "R5 flag early", pal_loaded, 0);
    end
    chk(stalls == 0, "R6 stalls in palette", stalls, 0);
    chk(fwd_seen == 0, "R6 fr_valid during palette", fwd_seen, 0);
    chk(pal_loaded == 1, "R7 flag after last word", pal_loaded, 1);
  endtask

  task automatic t_reset;
    #1;
    chk(s_ready == 0, "R1 reset s_ready", s_ready, 0);
    chk(pal_loaded == 0, "R1 reset flag", pal_loaded, 0);
    chk(fr_valid == 0, "R1 reset fr_valid", fr_valid, 0);
  endtask

  task automatic t_pal_only_8bpp;
    load_pal(2'd1, 4'h3, 1);
    s_valid = 1; #1;
    chk(s_ready == 0, "R7 hold s_ready", s_ready, 0);
    chk(fr_valid == 0, "R2 no frame in mode 1", fr_valid, 0);
    @(negedge clk); s_valid = 0;
    read_chk(0, "R4 entry 0");
    read_chk(1, "R3 upper halfword");
    read_chk(128, "R3 mid entry");
    read_chk(255, "R5 last of 256");
    clr_loaded = 1; @(negedge clk); clr_loaded = 0;
    chk(pal_loaded == 0, "R8 clear in mode 1", pal_loaded, 0);
    en = 0; @(negedge clk);
  endtask

  task automatic t_combined_16bpp;
    int waits;
    load_pal(2'd0, 4'h4, 2);
    read_chk(15, "R5 last of 16");
    read_chk(16, "R5 discarded word idx16");
    read_chk(17, "R5 discarded word idx17");
    read_chk(0, "R11 lookup entry 0");
    fr_ready = 0; s_valid = 1; s_data = 32'hCAFE_0123; #1;
    chk(fr_valid == 1, "R9 fr_valid", fr_valid, 1);
    chk(fr_data == 32'hCAFE_0123, "R9 fr_data", fr_data, 32'hCAFE_0123);
    chk(s_ready == 0, "R9 backpressure", s_ready, 0);
    fr_ready = 1; #1;
    chk(s_ready == 1, "R9 ready follows", s_ready, 1);
    @(negedge clk); s_valid = 0;
    clr_loaded = 1; @(negedge clk); clr_loaded = 0;
    chk(pal_loaded == 1, "R8 clear ignored in mode 0", pal_loaded, 1);
    en = 0; @(negedge clk); #1;
    chk(pal_loaded == 0, "R1 disable clears", pal_loaded, 0);
    chk(s_ready == 0, "R1 disabled s_ready", s_ready, 0);
  endtask

  task automatic t_pal_2bpp;
    load_pal(2'd1, 4'h1, 3);
    read_chk(127, "R5 last of 128");
    read_chk(128, "R5 beyond 128 kept");
    read_chk(0, "R4 entry 0 code 1");
    en = 0; @(negedge clk);
  endtask

  task automatic t_frame_only(input logic [1:0] mode);
    int waits;
    load_mode = mode; en = 1; fr_ready = 1;
    @(negedge clk);
    s_valid = 1; s_data = 32'h3FFF_3EEE; #1;
    chk(fr_valid == 1, "R2 frame-only starts in frame", fr_valid, 1);
    s_valid = 0;
    for (int i = 0; i < 4; i++) push(32'h3ABC_3DEF + i, waits);
    read_chk(0, "R10 entry 0 untouched");
    read_chk(1, "R10 entry 1 untouched");
    clr_loaded = 1; @(negedge clk); clr_loaded = 0;
    chk(pal_loaded == 0, "R8 flag low in frame-only", pal_loaded, 0);
    en = 0; @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_pal[i] = -1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_pal_only_8bpp;
    t_combined_16bpp;
    t_pal_2bpp;
    t_frame_only(2'd2);
    t_frame_only(2'd3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule